// File: doc/BRIEF.md
# Infrared Receive Auto-Stop Controller

This block decides when the receive path of a consumer infrared remote-control link is active. It watches the sampled receive bit stream, one bit per strobe, and counts how many zero bits arrive back to back. When that run reaches a programmable end-of-burst threshold, reception shuts itself off and a sticky stop flag is raised for the interrupt logic. The next one bit on the receive line turns reception back on without any help from software.

Software can also hold reception off directly through a disable input. While that input is high the receive-enable output is low, and bit strobes are ignored completely: they neither advance the zero-run count nor re-enable reception. A threshold of zero turns the automatic stop off, so only the software disable can halt reception. Demodulation and data buffering sit outside this block.

Top module: `cir_rx_autostop`

## Requirements
- R1: When `eob_thresh_i` is 0, no run of zero bits halts reception or sets `stop_flag_o`.
- R2: With a nonzero threshold N, each accepted strobe with `bit_val_i`=0 adds one to the zero-run count. After N-1 consecutive zeros, `rx_en_o` is still 1.
- R3: The accepted zero strobe that brings the run to N makes `rx_en_o` go to 0 and `stop_flag_o` go to 1 in the cycle after the clock edge that samples it.
- R4: An accepted strobe with `bit_val_i`=1 while reception is auto-halted makes `rx_en_o` 1 again after that clock edge.
- R5: An accepted strobe with `bit_val_i`=1 clears the zero-run count, so only consecutive zeros lead to a stop.
- R6: The count saturates at the threshold. Further zeros while halted do not set the flag again, and after a re-enable a full run of N zeros is needed to stop again.
- R7: While `sw_dis_i`=1, `rx_en_o` is 0 in the same cycle. Strobes neither change the count nor re-enable reception, and the auto-halt state is kept across the disable.
- R8: `stop_flag_o` stays 1 until a `flag_clr_i` pulse clears it. If a stop and a clear happen in the same cycle, the flag ends up 1.
- R9: Changes on `bit_val_i` while `bit_vld_i`=0 have no effect.
- R10: After reset, `rx_en_o` is 1, `stop_flag_o` is 0 and the zero-run count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: one received bit is present on bit_val_i |
| bit_val_i | input | 1 | Value of the received bit |
| eob_thresh_i | input | CNT_W | End-of-burst zero-run threshold; 0 turns the automatic stop off |
| sw_dis_i | input | 1 | Software receive disable, level |
| flag_clr_i | input | 1 | One-cycle pulse that clears the stop flag |
| rx_en_o | output | 1 | Reception enabled |
| stop_flag_o | output | 1 | Sticky receive-stop interrupt flag |

## Verification
The bench builds the block with its default 8-bit count width. The table-driven part uses a threshold of 3, so that counting, clearing on a one, saturation, software disable and the set-over-clear priority all fit in a few dozen cycles. Directed tests then use a threshold of 1, where a single zero stops reception, and the full-scale threshold of 255. The second case shows that the 8-bit counter reaches its top value without wrapping and stops on exactly the 255th zero.

// File: rtl/cir_rxstop_pkg.sv
package cir_rxstop_pkg;
  typedef enum logic {
    GATE_OPEN   = 1'b0,
    GATE_HALTED = 1'b1
  } gate_state_e;

  typedef struct packed {
    logic take;  // strobe accepted (valid and not disabled)
    logic one;   // accepted strobe carries a one
  } rx_bit_t;
endpackage

// File: rtl/cir_zero_run.sv
module cir_zero_run #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cir_rxstop_pkg::rx_bit_t bit_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] cnt_inc;
  logic             thr_on;
  logic             at_top;

  assign thr_on  = |thresh_i;
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign at_top  = cnt_inc >= {1'b0, thresh_i};
  assign hit_o   = bit_i.take && !bit_i.one && thr_on && at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (bit_i.take) begin
      if (bit_i.one || !thr_on) cnt_d = '0;
      else if (at_top)          cnt_d = thresh_i;   // saturate
      else                      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= thresh_i) |=> (cnt_q <= $past(thresh_i)));
  p_one_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i.take && bit_i.one) |=> (cnt_q == '0));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_i.take) |=> $stable(cnt_q));
endmodule

// File: rtl/cir_rx_gate.sv
module cir_rx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  cir_rxstop_pkg::rx_bit_t bit_i,
  input  logic hit_i,
  output logic halted_o,
  output logic stop_evt_o
);
  import cir_rxstop_pkg::*;

  gate_state_e st_q, st_d;

  assign stop_evt_o = hit_i && (st_q == GATE_OPEN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_OPEN:   if (hit_i)                    st_d = GATE_HALTED;
      GATE_HALTED: if (bit_i.take && bit_i.one)  st_d = GATE_OPEN;
      default:                                   st_d = GATE_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= GATE_OPEN;
    else         st_q <= st_d;
  end

  assign halted_o = (st_q == GATE_HALTED);

  p_stop_halts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt_o |=> halted_o);
  p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i.take && bit_i.one) |=> !halted_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_i.take) |=> $stable(halted_o));
endmodule

// File: rtl/cir_stop_flag.sv
module cir_stop_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cir_rx_autostop.sv
module cir_rx_autostop #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic [CNT_W-1:0] eob_thresh_i,
  input  logic             sw_dis_i,
  input  logic             flag_clr_i,
  output logic             rx_en_o,
  output logic             stop_flag_o
);
  import cir_rxstop_pkg::*;

  rx_bit_t          rx_bit;
  logic [CNT_W-1:0] run_cnt;
  logic             run_hit;
  logic             halted;
  logic             stop_evt;

  // software disable swallows strobes before they reach any state
  assign rx_bit.take = bit_vld_i && !sw_dis_i;
  assign rx_bit.one  = bit_val_i;

  cir_zero_run #(.CNT_W(CNT_W)) i_zero_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (rx_bit),
    .thresh_i (eob_thresh_i),
    .cnt_o    (run_cnt),
    .hit_o    (run_hit)
  );

  cir_rx_gate i_rx_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (rx_bit),
    .hit_i      (run_hit),
    .halted_o   (halted),
    .stop_evt_o (stop_evt)
  );

  cir_stop_flag i_stop_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stop_evt),
    .clr_i  (flag_clr_i),
    .flag_o (stop_flag_o)
  );

  assign rx_en_o = !sw_dis_i && !halted;

  p_thr_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eob_thresh_i == '0 && !stop_flag_o) |=> !stop_flag_o);
  p_sw_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_dis_i |=> ($stable(run_cnt) && $stable(halted)));
  p_sw_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_dis_i |-> !rx_en_o);
  p_flag_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_flag_o && !stop_evt) |=> !stop_flag_o);
endmodule

// File: tb/test_cir_rx_autostop.sv
module test_cir_rx_autostop;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned N_VEC = 31;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vld = 1'b0, val = 1'b0, sw = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] thr = '0;
  logic             en, flag;
  int               total = 0, bad = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cir_rx_autostop #(.CNT_W(CNT_W)) i_cir_rx_autostop (
    .clk_i (clk), .rst_ni (rst_n), .bit_vld_i (vld), .bit_val_i (val),
    .eob_thresh_i (thr), .sw_dis_i (sw), .flag_clr_i (clr),
    .rx_en_o (en), .stop_flag_o (flag)
  );

  // {req[3:0], vld, val, sw, clr, thr[7:0], exp_en, exp_flag}
  localparam logic [17:0] VEC [N_VEC] = '{
    {4'd10, 4'b0000, 8'd3, 2'b10},  // R10 idle after reset
    {4'd2,  4'b1000, 8'd3, 2'b10},  // R2 zero 1
    {4'd2,  4'b1000, 8'd3, 2'b10},  // R2 zero 2
    {4'd5,  4'b1100, 8'd3, 2'b10},  // R5 one clears run
    {4'd5,  4'b1000, 8'd3, 2'b10},
    {4'd5,  4'b1000, 8'd3, 2'b10},
    {4'd3,  4'b1000, 8'd3, 2'b01},  // R3 third zero stops
    {4'd6,  4'b1000, 8'd3, 2'b01},  // R6 saturated
    {4'd8,  4'b0001, 8'd3, 2'b00},  // R8 clear
    {4'd6,  4'b1000, 8'd3, 2'b00},  // R6 no second flag
    {4'd9,  4'b0100, 8'd3, 2'b00},  // R9 value without strobe
    {4'd4,  4'b1100, 8'd3, 2'b10},  // R4 one re-enables
    {4'd6,  4'b1000, 8'd3, 2'b10},
    {4'd6,  4'b1000, 8'd3, 2'b10},
    {4'd6,  4'b1000, 8'd3, 2'b01},  // R6 full run again
    {4'd7,  4'b1110, 8'd3, 2'b01},  // R7 one ignored under disable
    {4'd7,  4'b0000, 8'd3, 2'b01},  // R7 halt kept after release
    {4'd4,  4'b1100, 8'd3, 2'b11},
    {4'd7,  4'b0010, 8'd3, 2'b01},  // R7 immediate low
    {4'd7,  4'b1010, 8'd3, 2'b01},
    {4'd7,  4'b1010, 8'd3, 2'b01},
    {4'd7,  4'b1010, 8'd3, 2'b01},
    {4'd7,  4'b1000, 8'd3, 2'b11},  // R7 count frozen, now 1
    {4'd7,  4'b1000, 8'd3, 2'b11},  // 2
    {4'd8,  4'b1001, 8'd3, 2'b01},  // R8 set wins over clear
    {4'd4,  4'b1100, 8'd0, 2'b11},
    {4'd8,  4'b0001, 8'd0, 2'b10},
    {4'd1,  4'b1000, 8'd0, 2'b10},  // R1 threshold zero
    {4'd1,  4'b1000, 8'd0, 2'b10},
    {4'd1,  4'b1000, 8'd0, 2'b10},
    {4'd1,  4'b1000, 8'd0, 2'b10}
  };

  task automatic check(input string tag, input logic e_en, input logic e_flag);
    total++;
    if (en !== e_en || flag !== e_flag) begin
      bad++;
      $display("FAIL %s: en=%b flag=%b expected en=%b flag=%b", tag, en, flag, e_en, e_flag);
    end
  endtask

  // drive at negedge, edge samples, check at next negedge
  task automatic step(input logic v, input logic b, input logic s, input logic c,
                      input logic [CNT_W-1:0] t);
    vld = v; val = b; sw = s; clr = c; thr = t;
    @(negedge clk);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 in reset", 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:2]);
      check($sformatf("R%0d vec %0d", VEC[i][17:14], i), VEC[i][1], VEC[i][0]);
    end

    // R3 threshold 1: single zero stops
    step(1, 1, 0, 1, 8'd1);
    check("R4 rearm before thr1", 1'b1, 1'b0);
    step(1, 0, 0, 0, 8'd1);
    check("R3 thr1 single zero", 1'b0, 1'b1);
    step(1, 1, 0, 1, 8'd1);
    check("R4 rearm after thr1", 1'b1, 1'b0);

    // R2 full-scale threshold
    for (int k = 0; k < 254; k++) step(1, 0, 0, 0, 8'd255);
    check("R2 thr255 after 254 zeros", 1'b1, 1'b0);
    step(1, 0, 0, 0, 8'd255);
    check("R3 thr255 on 255th zero", 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 8'd255);
    check("R6 no wrap past 255", 1'b0, 1'b1);

    // R10 async reset mid-run
    vld = 1'b0; clr = 1'b0;
    #3 rst_n = 1'b0;
    #2 check("R10 async reset", 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 0, 0, 8'd2);
    check("R10 count zero after reset", 1'b1, 1'b0);
    step(1, 0, 0, 0, 8'd2);
    check("R3 stop after reset run", 1'b0, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule